// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block watches the two access ports of a shared two-port storage array. When both ports are selected and point at the same word in the same cycle, it lets one of them carry on and flags the other as busy. The flagged port's write strobe is suppressed inside the block, so the array never sees two competing writes to one word. The decision looks only at the selects and the addresses; it never considers whether either access reads or writes.

A mode input picks between two roles. As the master, the block arbitrates and drives an active-low busy flag for each port. As the slave, it does no arbitration; an active-low busy input per port then acts purely as a write inhibit for that port. This lets many slaves follow the decision of one master. The decision, the busy flags and the gated write enables are all registered. They are valid one cycle after the request is sampled, so the storage array must take each request one pipeline stage later.

Top module: `dp_collision_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both busy outputs are high (not busy) and both gated write enables are low.
- R2: In master mode a collision is both port selects high with equal addresses. Such a request makes exactly one busy output go low in the following cycle, including at the top address. Different addresses or a deselected port make neither go low.
- R3: When a collision starts with both ports newly on that address in the same cycle, the left port wins and only the right busy output goes low.
- R4: When one port already held the address in the previous cycle and the other port then joins it, the port that was there first wins and the latecomer is flagged busy.
- R5: A gated write enable is high one cycle after its port's select and write request are both high. It is low whenever that port is flagged busy. The winner's write passes unchanged.
- R6: Arbitration ignores the write requests: two reads of the same address flag the right port busy, exactly as two writes would.
- R7: A busy flag stays low, with the same loser, for as long as the collision persists. It returns high in the cycle after the addresses differ or either select drops.
- R8: In master mode the busy inputs have no effect on the gated write enables.
- R9: In slave mode no arbitration occurs and both busy outputs stay high. A low busy input blocks that port's writes, and a high one lets them through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_i | input | 1 | 1 = arbitrating master, 0 = slave following busy inputs |
| l_en_i | input | 1 | Left port select |
| l_addr_i | input | AW | Left port address |
| l_wr_i | input | 1 | Left port write request |
| l_busy_n_i | input | 1 | Left write inhibit in slave mode, active low |
| r_en_i | input | 1 | Right port select |
| r_addr_i | input | AW | Right port address |
| r_wr_i | input | 1 | Right port write request |
| r_busy_n_i | input | 1 | Right write inhibit in slave mode, active low |
| l_busy_n_o | output | 1 | Left port lost arbitration, active low |
| r_busy_n_o | output | 1 | Right port lost arbitration, active low |
| l_we_o | output | 1 | Gated left write enable for the array |
| r_we_o | output | 1 | Gated right write enable for the array |

## Verification
A stale or wrongly set loser flag shows up one cycle after the request as a low busy line with no collision, or as a write that should pass but is held off. A lost history of which port arrived first picks the wrong winner on the first collision cycle, and that choice stays wrong for the whole collision. Every stimulus step is therefore checked on the busy lines and both write enables in the cycle right after it. The steps run in sequence, so errors carried over between collisions are caught within one step.

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_i,
  input  logic          l_en_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          l_wr_i,
  input  logic          l_busy_n_i,
  input  logic          r_en_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic          r_wr_i,
  input  logic          r_busy_n_i,
  output logic          l_busy_n_o,
  output logic          r_busy_n_o,
  output logic          l_we_o,
  output logic          r_we_o
);

  logic          l_en_q, r_en_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          l_lose_q, r_lose_q, l_lose_d, r_lose_d;
  logic          l_we_q, r_we_q;

  wire hit    = l_en_i & r_en_i & (l_addr_i == r_addr_i);
  wire l_stay = l_en_q & (l_addr_q == l_addr_i);
  wire r_stay = r_en_q & (r_addr_q == r_addr_i);
  wire held   = l_lose_q | r_lose_q;

  always_comb begin
    l_lose_d = 1'b0;
    r_lose_d = 1'b0;
    if (master_i && hit) begin
      if (held) begin
        l_lose_d = l_lose_q;
        r_lose_d = r_lose_q;
      end else if (r_stay && !l_stay) begin
        l_lose_d = 1'b1;
      end else begin
        r_lose_d = 1'b1;
      end
    end
  end

  wire l_ok = master_i ? ~l_lose_d : l_busy_n_i;
  wire r_ok = master_i ? ~r_lose_d : r_busy_n_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      l_lose_q <= 1'b0;
      r_lose_q <= 1'b0;
      l_we_q   <= 1'b0;
      r_we_q   <= 1'b0;
    end else begin
      l_en_q   <= l_en_i;
      r_en_q   <= r_en_i;
      l_addr_q <= l_addr_i;
      r_addr_q <= r_addr_i;
      l_lose_q <= l_lose_d;
      r_lose_q <= r_lose_d;
      l_we_q   <= l_en_i & l_wr_i & l_ok;
      r_we_q   <= r_en_i & r_wr_i & r_ok;
    end
  end

  assign l_busy_n_o = ~l_lose_q;
  assign r_busy_n_o = ~r_lose_q;
  assign l_we_o     = l_we_q;
  assign r_we_o     = r_we_q;

  assert_one_loser_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~l_busy_n_o, ~r_busy_n_o}));

  assert_no_busy_without_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(master_i && l_en_i && r_en_i && (l_addr_i == r_addr_i)) |=> (l_busy_n_o && r_busy_n_o));

  assert_left_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n_o |-> !l_we_o);

  assert_right_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n_o |-> !r_we_o);

  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |=> (l_busy_n_o && r_busy_n_o));

  assert_slave_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && (!l_busy_n_i || !r_busy_n_i)) |=> !((!$past(l_busy_n_i) && l_we_o) || (!$past(r_busy_n_i) && r_we_o)));

endmodule

// File: tb/tb_dp_collision_arbiter.sv
module tb_dp_collision_arbiter;
  localparam int AW = 13;
  localparam int N  = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_i = 1'b1;
  logic l_en_i = 1'b0, l_wr_i = 1'b0, l_busy_n_i = 1'b1;
  logic r_en_i = 1'b0, r_wr_i = 1'b0, r_busy_n_i = 1'b1;
  logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
  logic l_busy_n_o, r_busy_n_o, l_we_o, r_we_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dp_collision_arbiter #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .master_i(master_i),
    .l_en_i(l_en_i), .l_addr_i(l_addr_i), .l_wr_i(l_wr_i), .l_busy_n_i(l_busy_n_i),
    .r_en_i(r_en_i), .r_addr_i(r_addr_i), .r_wr_i(r_wr_i), .r_busy_n_i(r_busy_n_i),
    .l_busy_n_o(l_busy_n_o), .r_busy_n_o(r_busy_n_o), .l_we_o(l_we_o), .r_we_o(r_we_o)
  );

  // {req, mode, l_en, l_addr, l_wr, l_bin, r_en, r_addr, r_wr, r_bin, exp l_busy_n, r_busy_n, l_we, r_we}
  localparam logic [40:0] VEC [0:N-1] = '{
    {4'd2, 1'b1, 1'b1, 13'h0010, 1'b1, 1'b1, 1'b1, 13'h0020, 1'b1, 1'b1, 4'b1111}, // R2 distinct
    {4'd3, 1'b1, 1'b1, 13'h0100, 1'b1, 1'b1, 1'b1, 13'h0100, 1'b1, 1'b1, 4'b1010}, // R3 tie
    {4'd7, 1'b1, 1'b1, 13'h0100, 1'b1, 1'b1, 1'b1, 13'h0100, 1'b1, 1'b1, 4'b1010}, // R7 held
    {4'd7, 1'b1, 1'b1, 13'h0100, 1'b1, 1'b1, 1'b1, 13'h0101, 1'b1, 1'b1, 4'b1111}, // R7 address moves
    {4'd4, 1'b1, 1'b1, 13'h0200, 1'b1, 1'b1, 1'b1, 13'h0101, 1'b0, 1'b1, 4'b1110}, // R4 left settles
    {4'd4, 1'b1, 1'b1, 13'h0200, 1'b1, 1'b1, 1'b1, 13'h0200, 1'b1, 1'b1, 4'b1010}, // R4 right joins late
    {4'd4, 1'b1, 1'b0, 13'h0300, 1'b1, 1'b1, 1'b1, 13'h0300, 1'b1, 1'b1, 4'b1101}, // R4 right settles
    {4'd4, 1'b1, 1'b1, 13'h0300, 1'b1, 1'b1, 1'b1, 13'h0300, 1'b1, 1'b1, 4'b0101}, // R4 left joins late
    {4'd7, 1'b1, 1'b0, 13'h0300, 1'b1, 1'b1, 1'b1, 13'h0300, 1'b1, 1'b1, 4'b1101}, // R7 select drops
    {4'd6, 1'b1, 1'b1, 13'h0400, 1'b0, 1'b1, 1'b1, 13'h0400, 1'b0, 1'b1, 4'b1000}, // R6 two reads
    {4'd6, 1'b1, 1'b0, 13'h0400, 1'b0, 1'b1, 1'b0, 13'h0400, 1'b0, 1'b1, 4'b1100}, // R6 release
    {4'd8, 1'b1, 1'b1, 13'h0500, 1'b1, 1'b0, 1'b1, 13'h0600, 1'b1, 1'b0, 4'b1111}, // R8 inputs ignored
    {4'd9, 1'b0, 1'b1, 13'h0700, 1'b1, 1'b1, 1'b1, 13'h0700, 1'b1, 1'b1, 4'b1111}, // R9 no arbitration
    {4'd9, 1'b0, 1'b1, 13'h0700, 1'b1, 1'b0, 1'b1, 13'h0700, 1'b1, 1'b1, 4'b1101}, // R9 left inhibited
    {4'd9, 1'b0, 1'b1, 13'h0700, 1'b1, 1'b1, 1'b1, 13'h0700, 1'b1, 1'b0, 4'b1110}, // R9 right inhibited
    {4'd3, 1'b1, 1'b1, 13'h0700, 1'b1, 1'b1, 1'b1, 13'h0700, 1'b1, 1'b1, 4'b1010}, // R3 both present at switch
    {4'd2, 1'b1, 1'b1, 13'h1FFF, 1'b1, 1'b1, 1'b1, 13'h1FFF, 1'b0, 1'b1, 4'b1010}, // R2 top address
    {4'd5, 1'b1, 1'b1, 13'h1FFF, 1'b0, 1'b1, 1'b1, 13'h1FFF, 1'b1, 1'b1, 4'b1000}, // R5 loser write blocked
    {4'd5, 1'b1, 1'b0, 13'h0010, 1'b1, 1'b1, 1'b0, 13'h0010, 1'b1, 1'b1, 4'b1100}  // R5 no select no write
  };

  task automatic check(input int req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: {lbusy_n,rbusy_n,lwe,rwe} got %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1, {l_busy_n_o, r_busy_n_o, l_we_o, r_we_o}, 4'b1100); // R1 in reset
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1
    check(1, {l_busy_n_o, r_busy_n_o, l_we_o, r_we_o}, 4'b1100);    // R1 after release

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      master_i   = VEC[i][36];
      l_en_i     = VEC[i][35];
      l_addr_i   = VEC[i][34:22];
      l_wr_i     = VEC[i][21];
      l_busy_n_i = VEC[i][20];
      r_en_i     = VEC[i][19];
      r_addr_i   = VEC[i][18:6];
      r_wr_i     = VEC[i][5];
      r_busy_n_i = VEC[i][4];
      @(posedge clk); #1
      check(int'(VEC[i][40:37]), {l_busy_n_o, r_busy_n_o, l_we_o, r_we_o}, VEC[i][3:0]);
    end

    // R1: reset during an ongoing collision clears the loser and the writes
    @(negedge clk);
    master_i = 1'b1; l_en_i = 1'b1; r_en_i = 1'b1; l_wr_i = 1'b1; r_wr_i = 1'b1;
    l_addr_i = 13'h0AAA; r_addr_i = 13'h0AAA;
    @(posedge clk); #1
    check(3, {l_busy_n_o, r_busy_n_o, l_we_o, r_we_o}, 4'b1010);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1
    check(1, {l_busy_n_o, r_busy_n_o, l_we_o, r_we_o}, 4'b1100);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1
    check(3, {l_busy_n_o, r_busy_n_o, l_we_o, r_we_o}, 4'b1010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule